// File: doc/BRIEF.md
# Multi-channel match counter bank

The block holds eight timer channels, numbered 4 to 11. Each has a 32-bit counter, a 32-bit match value and a control word. The control word picks which of five tick-enable inputs advances the counter. It also sets three behaviours: whether a match clears the counter, whether matching re-arms after a hit, and whether an odd channel compares against its even neighbour's counter instead of its own. Channels 9 and 11 can also capture their even partner's counter into a shared snapshot register when their own counter is read.

Software reaches the block through a simple register port. A write takes effect at the clock edge on which `wr_en` is high. A read strobe at one edge returns its data on `rdata` after that edge. A match sets a status bit when that channel's enable bit is set. One interrupt output stays high while any status bit is set.

A "hit" is defined as follows. On a cycle when the channel's compare counter takes a count step, the value that step produces equals the channel's match value. For a borrowing channel, the compare counter is the neighbour's counter, and the stepped value is that counter plus one.

Each channel runs a two-state match machine. ARMED is the reset state. A hit in ARMED with periodic mode off moves the channel to SPENT. A hit with periodic mode on leaves it in ARMED. In SPENT, no hit can occur. A write to that channel's counter or match register moves the machine from either state back to ARMED.

Top module: `xtimer_bank`

## Requirements
- R1: After reset, every counter, match, control, enable, status and snapshot register reads 0, and `irq` is low.
- R2: The register map is as follows: counter n at 0x40+4*(n-4), match n at 0x80+4*(n-4), control n at 0xC0+4*(n-4), status at 0x14, enable at 0x1C and snapshot at 0x20. Read data appears on `rdata` after the edge that samples `rd_en`. A control write keeps bits [7:0] for channels 4 to 7 and bits [9:0] for channels 8 to 11.
- R3: Control bits [2:0] select the rate. Code 1 to 5 selects `tick_en[0]` to `tick_en[4]`, and codes 0, 6 and 7 stop the counter. A running counter gains 1 on each edge where its selected tick is high. A rate change keeps the counter's value.
- R4: When control bit 7 is clear, odd channels 5, 7, 9 and 11 compare against the counter of channel n-1, and their own counter holds its value. Channels 4, 6, 8 and 10 always use their own counter.
- R5: On channels 8 to 11, control bit 8 set holds the channel's own counter whatever the rate code.
- R6: When control bit 3 is set, a hit loads the channel's own counter with 0 instead of the stepped value.
- R7: When control bit 6 is clear, a channel hits at most once, until its counter or match register is written. When bit 6 is set, it stays armed after every hit.
- R8: On channels 9 and 11 with control bit 9 set, a read of that channel's counter copies the current value of counter 8 or counter 10 into the snapshot register. With bit 9 clear, the snapshot register keeps its value.
- R9: A hit on channel n sets status bit n only when enable bit n is set. Writing to the status register clears each bit written as 1. A hit in the same cycle as a clear of its own bit leaves that bit set.
- R10: `irq` is high exactly while any status bit 4 to 11 is set. It rises after the edge that records a hit and falls after the edge of the clear that leaves no bit set.
- R11: A counter write loads the value directly. The write takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| tick_en | input | 5 | Rate tick enables, one per rate code 1 to 5 |
| irq | output | 1 | Combined match interrupt |

## Verification
Two things can fall in the same cycle: a hit that sets a status bit, and a software clear of that same bit. The bench provokes this by holding the selected tick high during the cycle that writes the status clear, with the counter one step below its match value. It judges the result by reading status and checking that the bit stayed set and `irq` stayed high. In the same way, a counter write is issued with its tick held high, and the readback must show the written value, not that value plus one.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int FIRST_CH  = 4;
    localparam int NARROW_N  = 4;
    localparam int CTRL_W    = 10;

    // control word bit positions
    localparam int CB_CLR    = 3;
    localparam int CB_PER    = 6;
    localparam int CB_OWN    = 7;
    localparam int CB_HALT   = 8;
    localparam int CB_SNAP   = 9;

    // address regions, addr[7:5]
    localparam logic [2:0] RG_CNT  = 3'b010;
    localparam logic [2:0] RG_MAT  = 3'b100;
    localparam logic [2:0] RG_CTL  = 3'b110;
    localparam logic [7:0] AD_STAT = 8'h14;
    localparam logic [7:0] AD_IEN  = 8'h1C;
    localparam logic [7:0] AD_SNAP = 8'h20;

    typedef enum logic {
        MS_ARMED = 1'b0,
        MS_SPENT = 1'b1
    } match_st_e;
endpackage

// File: rtl/xtb_rate_sel.sv
module xtb_rate_sel #(
    parameter int N_TICK = 5
) (
    input  logic [2:0]        code,
    input  logic [N_TICK-1:0] tick_en,
    output logic              tick
);
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < N_TICK; k++) begin
            if (code == 3'(k + 1)) tick = tick_en[k];
        end
    end
endmodule

// File: rtl/xtb_channel.sv
module xtb_channel
    import xtb_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              rate_tick,
    input  logic              cnt_wr,
    input  logic              mat_wr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  nb_cnt,
    input  logic              nb_step,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  mat_q,
    output logic              step_o,
    output logic              hit_o
);
    localparam bit ODD = (IDX % 2) == 1;
    localparam bit EXT = IDX >= NARROW_N;

    match_st_e        st_q, st_d;
    logic             borrow, halted, step_own, src_step;
    logic [CNT_W-1:0] src_cnt, src_next;

    assign borrow   = ODD && !ctrl[CB_OWN];
    assign halted   = borrow || (EXT && ctrl[CB_HALT]);
    assign step_own = rate_tick && !halted && !cnt_wr;
    assign src_cnt  = borrow ? nb_cnt  : cnt_q;
    assign src_step = borrow ? nb_step : step_own;
    assign src_next = src_cnt + CNT_W'(1);
    assign step_o   = step_own;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MS_ARMED;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MS_ARMED: begin
                if (cnt_wr || mat_wr)             st_d = MS_ARMED;
                else if (hit_o && !ctrl[CB_PER])  st_d = MS_SPENT;
            end
            MS_SPENT: begin
                if (cnt_wr || mat_wr)             st_d = MS_ARMED;
            end
        endcase
    end

    // outputs
    always_comb begin
        hit_o = (st_q == MS_ARMED) && src_step && (src_next == mat_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mat_q <= '0;
        end else begin
            if (cnt_wr)                      cnt_q <= wdata;
            else if (hit_o && ctrl[CB_CLR])  cnt_q <= '0;
            else if (step_own)               cnt_q <= cnt_q + CNT_W'(1);
            if (mat_wr)                      mat_q <= wdata;
        end
    end

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_own && !(hit_o && ctrl[CB_CLR]) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    a_r4_borrow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        borrow && !cnt_wr && !(hit_o && ctrl[CB_CLR]) |=> cnt_q == $past(cnt_q));
    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        EXT && ctrl[CB_HALT] && !cnt_wr && !(hit_o && ctrl[CB_CLR]) |=> cnt_q == $past(cnt_q));
    a_r6_clear_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o && ctrl[CB_CLR] && !cnt_wr |=> cnt_q == '0);
    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o && !ctrl[CB_PER] && !cnt_wr && !mat_wr |=> !hit_o);
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wdata));
endmodule

// File: rtl/xtb_irq.sv
module xtb_irq #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit_vec,
    input  logic [N_CH-1:0] ien,
    input  logic            clr_wr,
    input  logic [N_CH-1:0] clr_mask,
    output logic [N_CH-1:0] status_q,
    output logic            irq
);
    logic [N_CH-1:0] set_v, keep_v;

    assign set_v  = hit_vec & ien;
    assign keep_v = clr_wr ? (status_q & ~clr_mask) : status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= keep_v | set_v;
    end

    assign irq = |status_q;

    a_r9_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        |set_v |=> irq);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && |(set_v & clr_mask) |=> |(status_q & $past(set_v)));
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && set_v == '0 && (status_q & ~clr_mask) == '0 |=> !irq);
endmodule

// File: rtl/xtimer_bank.sv
module xtimer_bank
    import xtb_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int N_TICK = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_TICK-1:0] tick_en,
    output logic              irq
);
    localparam int IDX_W = $clog2(N_CH);

    logic [2:0]       region;
    logic [IDX_W-1:0] idx;
    logic             aligned, in_cnt, in_mat, in_ctl;

    assign region  = addr[7:5];
    assign idx     = addr[2 +: IDX_W];
    assign aligned = addr[1:0] == 2'b00;
    assign in_cnt  = aligned && region == RG_CNT;
    assign in_mat  = aligned && region == RG_MAT;
    assign in_ctl  = aligned && region == RG_CTL;

    logic [CTRL_W-1:0] ctrl_q  [N_CH];
    logic [CNT_W-1:0]  cnt_q   [N_CH];
    logic [CNT_W-1:0]  mat_q   [N_CH];
    logic [CNT_W-1:0]  nb_cnt  [N_CH];
    logic [N_CH-1:0]   nb_step, step_v, hit_v, rate_v;
    logic [N_CH-1:0]   ien_q, status_q;
    logic [DATA_W-1:0] snap_q;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam int KEEP = (i < NARROW_N) ? 8 : CTRL_W;
        localparam logic [CTRL_W-1:0] MASK = CTRL_W'((1 << KEEP) - 1);
        logic sel_here;

        assign sel_here = idx == IDX_W'(i);

        always_ff @(posedge clk) begin
            if (!rst_n)                          ctrl_q[i] <= '0;
            else if (wr_en && in_ctl && sel_here) ctrl_q[i] <= wdata[CTRL_W-1:0] & MASK;
        end

        if (i % 2 == 1) begin : g_nb
            assign nb_cnt[i]  = cnt_q[i-1];
            assign nb_step[i] = step_v[i-1];
        end else begin : g_solo
            assign nb_cnt[i]  = '0;
            assign nb_step[i] = 1'b0;
        end

        xtb_rate_sel #(.N_TICK(N_TICK)) u_rate (
            .code    (ctrl_q[i][2:0]),
            .tick_en (tick_en),
            .tick    (rate_v[i])
        );

        xtb_channel #(.CNT_W(CNT_W), .IDX(i)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (ctrl_q[i]),
            .rate_tick (rate_v[i]),
            .cnt_wr    (wr_en && in_cnt && sel_here),
            .mat_wr    (wr_en && in_mat && sel_here),
            .wdata     (wdata[CNT_W-1:0]),
            .nb_cnt    (nb_cnt[i]),
            .nb_step   (nb_step[i]),
            .cnt_q     (cnt_q[i]),
            .mat_q     (mat_q[i]),
            .step_o    (step_v[i]),
            .hit_o     (hit_v[i])
        );
    end

    xtb_irq #(.N_CH(N_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_v),
        .ien      (ien_q),
        .clr_wr   (wr_en && addr == AD_STAT),
        .clr_mask (wdata[FIRST_CH +: N_CH]),
        .status_q (status_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                       ien_q <= '0;
        else if (wr_en && addr == AD_IEN) ien_q <= wdata[FIRST_CH +: N_CH];
    end

    // snapshot capture on a counter read of an odd wide channel
    logic              snap_take;
    logic [DATA_W-1:0] snap_val;

    always_comb begin
        snap_take = 1'b0;
        snap_val  = '0;
        for (int i = 0; i < N_CH; i++) begin
            if ((i % 2 == 1) && (i >= NARROW_N) && rd_en && in_cnt &&
                idx == IDX_W'(i) && ctrl_q[i][CB_SNAP]) begin
                snap_take = 1'b1;
                snap_val  = DATA_W'(nb_cnt[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_take) snap_q <= snap_val;
    end

    // registered read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (in_cnt)                rdata <= DATA_W'(cnt_q[idx]);
            else if (in_mat)           rdata <= DATA_W'(mat_q[idx]);
            else if (in_ctl)           rdata <= DATA_W'(ctrl_q[idx]);
            else if (addr == AD_STAT)  rdata <= DATA_W'(status_q) << FIRST_CH;
            else if (addr == AD_IEN)   rdata <= DATA_W'(ien_q) << FIRST_CH;
            else if (addr == AD_SNAP)  rdata <= snap_q;
            else                       rdata <= '0;
        end
    end

    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && in_cnt) |=> snap_q == $past(snap_q));
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/xtimer_bank_test.sv
`timescale 1ns/1ps
module xtimer_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  tick_en = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    xtimer_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq)
    );

    function automatic logic [7:0] a_cnt(int n); return 8'(8'h40 + 4 * (n - 4)); endfunction
    function automatic logic [7:0] a_mat(int n); return 8'(8'h80 + 4 * (n - 4)); endfunction
    function automatic logic [7:0] a_ctl(int n); return 8'(8'hC0 + 4 * (n - 4)); endfunction
    localparam logic [7:0] A_STAT = 8'h14, A_IEN = 8'h1C, A_SNAP = 8'h20;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // driver: push expected item, then strobe the read
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input int k, input int n);
        @(negedge clk); tick_en[k] = 1'b1;
        repeat (n) @(negedge clk);
        tick_en[k] = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: compare returned read data against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) chk(rdata, 32'hx, "unexpected read");
                else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({31'b0, irq}, 0, "R1 irq after reset");
        rd(a_cnt(4), 0, "R1 counter 4");
        rd(a_ctl(11), 0, "R1 control 11");
        rd(A_SNAP, 0, "R1 snapshot");
        rd(A_STAT, 0, "R1 status");
        // R2 control write masks
        wr(a_ctl(4), 32'hFFFF);
        rd(a_ctl(4), 32'hFF, "R2 narrow mask");
        wr(a_ctl(8), 32'hFFFF);
        rd(a_ctl(8), 32'h3FF, "R2 wide mask");
        wr(a_ctl(8), 0);
        // R3 rate select and hold on rate change
        wr(a_ctl(4), 1);
        pulse(0, 5);
        rd(a_cnt(4), 5, "R3 rate code 1");
        pulse(1, 3);
        rd(a_cnt(4), 5, "R3 other tick ignored");
        wr(a_ctl(4), 2);
        pulse(1, 2);
        rd(a_cnt(4), 7, "R3 rate change holds value");
        wr(a_ctl(4), 6);
        for (int k = 0; k < 5; k++) pulse(k, 1);
        rd(a_cnt(4), 7, "R3 code 6 stopped");
        // R11 load, precedence over tick
        wr(a_cnt(4), 100);
        rd(a_cnt(4), 100, "R11 load");
        wr(a_ctl(4), 2);
        @(negedge clk); tick_en[1] = 1'b1; wr_en = 1'b1; addr = a_cnt(4); wdata = 200;
        @(negedge clk); tick_en[1] = 1'b0; wr_en = 1'b0;
        rd(a_cnt(4), 200, "R11 write beats tick");
        // R4 borrow
        wr(a_ctl(4), 1);
        wr(a_ctl(5), 1);
        wr(a_cnt(4), 0);
        wr(a_mat(5), 3);
        wr(A_IEN, 32'h430);
        pulse(0, 3);
        chk({31'b0, irq}, 1, "R10 irq after borrowed hit");
        rd(A_STAT, 32'h20, "R4 borrowed hit status");
        rd(a_cnt(5), 0, "R4 own counter holds");
        wr(A_STAT, 32'h20);
        chk({31'b0, irq}, 0, "R10 irq after clear");
        rd(A_STAT, 0, "R9 clear");
        wr(a_ctl(5), 32'h81);
        pulse(0, 2);
        rd(a_cnt(5), 2, "R4 own counter with bit 7");
        // R9 enable gating
        wr(a_ctl(6), 1);
        wr(a_mat(6), 2);
        pulse(0, 2);
        rd(A_STAT, 0, "R9 disabled channel");
        chk({31'b0, irq}, 0, "R10 no irq when disabled");
        // R6 clear on hit
        wr(a_ctl(4), 32'h09);
        wr(a_cnt(4), 0);
        wr(a_mat(4), 4);
        pulse(0, 4);
        rd(a_cnt(4), 0, "R6 cleared on hit");
        rd(A_STAT, 32'h10, "R6 hit status");
        pulse(0, 1);
        rd(a_cnt(4), 1, "R6 counts on after clear");
        wr(A_STAT, 32'h10);
        // R7 one-shot spent, re-armed by match write
        pulse(0, 3);
        rd(a_cnt(4), 4, "R7 spent no clear");
        rd(A_STAT, 0, "R7 spent no status");
        wr(a_mat(4), 6);
        pulse(0, 2);
        rd(a_cnt(4), 0, "R7 rearmed hit");
        rd(A_STAT, 32'h10, "R7 rearmed status");
        wr(A_STAT, 32'h10);
        // R7 periodic
        wr(a_ctl(10), 32'h49);
        wr(a_cnt(10), 0);
        wr(a_mat(10), 2);
        pulse(0, 2);
        rd(A_STAT, 32'h400, "R7 periodic first");
        wr(A_STAT, 32'h400);
        pulse(0, 2);
        rd(A_STAT, 32'h400, "R7 periodic second");
        wr(A_STAT, 32'h400);
        wr(a_ctl(10), 0);
        // R5 halt
        wr(a_ctl(8), 32'h101);
        pulse(0, 3);
        rd(a_cnt(8), 0, "R5 halted");
        wr(a_ctl(8), 1);
        pulse(0, 3);
        rd(a_cnt(8), 3, "R5 released");
        wr(a_ctl(8), 0);
        // R8 snapshot
        wr(a_ctl(9), 32'h200);
        rd(a_cnt(9), 0, "R8 counter 9");
        rd(A_SNAP, 3, "R8 snapshot of 8");
        wr(a_ctl(9), 0);
        wr(a_cnt(8), 50);
        rd(a_cnt(9), 0, "R8 counter 9 no snap");
        rd(A_SNAP, 3, "R8 snapshot kept");
        // R9 set wins over clear
        wr(a_cnt(4), 0);
        wr(a_mat(4), 1);
        wr(a_ctl(4), 32'h49);
        @(negedge clk); tick_en[0] = 1'b1; wr_en = 1'b1; addr = A_STAT; wdata = 32'h10;
        @(negedge clk); tick_en[0] = 1'b0; wr_en = 1'b0;
        rd(A_STAT, 32'h10, "R9 set wins");
        chk({31'b0, irq}, 1, "R10 irq held");
        wr(A_STAT, 32'h10);
        chk({31'b0, irq}, 0, "R10 irq dropped");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) chk(32'(exp_q.size()), 0, "scoreboard drained");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule